// File: doc/BRIEF.md
# Software Interrupt Entry Sequencer

This block carries out the context-save and vector-fetch part of a software interrupt on an 8-bit processor with a 16-bit address space. A one-cycle `start` pulse latches the current program counter, stack pointer, accumulator, index byte and condition codes. Over the following nine clock cycles the block drives a single-port byte memory bus.

The sequence runs in fixed steps. The saved program counter is first advanced by one. Five context bytes are then written onto a stack that grows toward lower addresses. The interrupt-mask bit of the condition codes is set. Finally the two bytes of the handler address are read from a fixed pair of vector locations.

The surrounding core supplies the register values and takes back the new PC, SP and condition codes when `done` pulses. Opcode decode, arithmetic, hardware interrupt priority and the return path belong to other blocks.

Top module: `swiEntrySeq`

## Requirements
- R1: A `start` sampled high while idle latches all register inputs and begins a sequence. The first cycle after acceptance performs no bus write. The PC value that is stacked is the latched PC plus one, modulo 2^16.
- R2: The five stack writes occur in cycles 2 to 6 after acceptance, in this order: incremented PC bits [7:0], incremented PC bits [15:8], index byte, accumulator, condition codes.
- R3: Each write goes to the current SP, and SP then drops by one, modulo 2^16. The addresses are therefore SP, SP−1, …, SP−4, and the final SP is SP−5.
- R4: The condition-code byte that is stacked is the value before the sequence. Afterwards bit 3 (the interrupt mask) is set to 1 and every other bit is unchanged.
- R5: The vector high byte is read from address 0xFFFC and then the low byte from 0xFFFD. Read data arrives one cycle after the address. The final PC is {byte at 0xFFFC, byte at 0xFFFD}.
- R6: `done` is high for exactly one cycle, the ninth cycle after acceptance. In that cycle `pcOut`, `spOut` and `ccrOut` carry the final values, and they hold those values afterwards while idle.
- R7: `start` has no effect while a sequence runs, including in its ninth cycle. The sequence's writes and results are unchanged, and no new sequence follows.
- R8: During reset and right after it, `done` and `memWe` are low and `pcOut`, `spOut`, `ccrOut` are zero.
- R9: Exactly five writes occur per sequence, and none occur while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request to begin the entry sequence |
| pcIn | input | 16 | Program counter at the trap |
| spIn | input | 16 | Stack pointer at the trap (next free byte) |
| aIn | input | 8 | Accumulator |
| xIn | input | 8 | Index byte |
| ccrIn | input | 8 | Condition codes |
| memAddr | output | 16 | Memory byte address |
| memWdata | output | 8 | Byte to write |
| memWe | output | 1 | Write enable |
| memRdata | input | 8 | Read data, valid one cycle after its address |
| done | output | 1 | Pulses in the final cycle of the sequence |
| pcOut | output | 16 | Resulting program counter |
| spOut | output | 16 | Resulting stack pointer |
| ccrOut | output | 8 | Resulting condition codes |

## Verification
The completion cycle and a fresh request can coincide: the ninth cycle raises `done` while the core may already be asserting `start` for the next trap. The bench holds `start` high through that cycle in some runs. It also pulses `start` again, with different register values, in the middle of the stacking phase. It then judges that the write log, the final PC/SP/condition codes and the single `done` pulse match what is computed from the first request, and that no further writes appear. The sweep includes a stack pointer near zero, so the push addresses wrap past 0x0000, and a PC of 0xFFFF, so the increment carries across both bytes.

// File: rtl/swiSeqPkg.sv
package swiSeqPkg;
  localparam int SEQ_STEPS = 9;

  typedef enum logic [2:0] {
    PUSH_PCL = 3'd0,
    PUSH_PCH = 3'd1,
    PUSH_X   = 3'd2,
    PUSH_A   = 3'd3,
    PUSH_CCR = 3'd4
  } pushSel_e;

  typedef struct packed {
    logic     load;
    logic     incPc;
    logic     push;
    pushSel_e pushSel;
    logic     setMask;
    logic     rdVec;
    logic     vecLo;
    logic     ldPcHi;
    logic     finish;
  } seqCtl_t;
endpackage

// File: rtl/swiSeqCtrl.sv
module swiSeqCtrl
  import swiSeqPkg::*;
#(
  parameter int STEP_W = 4
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    start,
  output seqCtl_t ctl
);
  localparam logic [STEP_W-1:0] LAST = STEP_W'(SEQ_STEPS);

  logic [STEP_W-1:0] step;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      step <= '0;
    end else if (step == '0) begin
      if (start) step <= STEP_W'(1);
    end else if (step == LAST) begin
      step <= '0;
    end else begin
      step <= step + STEP_W'(1);
    end
  end

  always_comb begin
    ctl         = '0;
    ctl.pushSel = PUSH_PCL;
    ctl.load    = (step == '0) && start;
    case (step)
      STEP_W'(1): ctl.incPc = 1'b1;
      STEP_W'(2): begin ctl.push = 1'b1; ctl.pushSel = PUSH_PCL; end
      STEP_W'(3): begin ctl.push = 1'b1; ctl.pushSel = PUSH_PCH; end
      STEP_W'(4): begin ctl.push = 1'b1; ctl.pushSel = PUSH_X;   end
      STEP_W'(5): begin ctl.push = 1'b1; ctl.pushSel = PUSH_A;   end
      STEP_W'(6): begin ctl.push = 1'b1; ctl.pushSel = PUSH_CCR; ctl.setMask = 1'b1; end
      STEP_W'(7): ctl.rdVec = 1'b1;
      STEP_W'(8): begin ctl.rdVec = 1'b1; ctl.vecLo = 1'b1; ctl.ldPcHi = 1'b1; end
      STEP_W'(9): ctl.finish = 1'b1;
      default: ;
    endcase
  end
endmodule

// File: rtl/swiSeqDatapath.sv
module swiSeqDatapath
  import swiSeqPkg::*;
#(
  parameter int              ADDR_W   = 16,
  parameter int              DATA_W   = 8,
  parameter logic [ADDR_W-1:0] VEC_BASE = 16'hFFFC,
  parameter int              MASK_BIT = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqCtl_t           ctl,
  input  logic [ADDR_W-1:0] pcIn,
  input  logic [ADDR_W-1:0] spIn,
  input  logic [DATA_W-1:0] aIn,
  input  logic [DATA_W-1:0] xIn,
  input  logic [DATA_W-1:0] ccrIn,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  output logic              memWe,
  input  logic [DATA_W-1:0] memRdata,
  output logic              done,
  output logic [ADDR_W-1:0] pcOut,
  output logic [ADDR_W-1:0] spOut,
  output logic [DATA_W-1:0] ccrOut
);
  localparam int HI_LSB = ADDR_W - DATA_W;

  logic [ADDR_W-1:0] pcReg, spReg;
  logic [DATA_W-1:0] aReg, xReg, ccrReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pcReg  <= '0;
      spReg  <= '0;
      aReg   <= '0;
      xReg   <= '0;
      ccrReg <= '0;
    end else begin
      if (ctl.load) begin
        pcReg  <= pcIn;
        spReg  <= spIn;
        aReg   <= aIn;
        xReg   <= xIn;
        ccrReg <= ccrIn;
      end
      if (ctl.incPc)   pcReg <= pcReg + ADDR_W'(1);
      if (ctl.push)    spReg <= spReg - ADDR_W'(1);
      if (ctl.setMask) ccrReg[MASK_BIT] <= 1'b1;
      if (ctl.ldPcHi)  pcReg[ADDR_W-1:HI_LSB] <= memRdata;
      if (ctl.finish)  pcReg[DATA_W-1:0] <= memRdata;
    end
  end

  always_comb begin
    case (ctl.pushSel)
      PUSH_PCL: memWdata = pcReg[DATA_W-1:0];
      PUSH_PCH: memWdata = pcReg[ADDR_W-1:HI_LSB];
      PUSH_X:   memWdata = xReg;
      PUSH_A:   memWdata = aReg;
      PUSH_CCR: memWdata = ccrReg;
      default:  memWdata = '0;
    endcase
  end

  assign memWe   = ctl.push;
  assign memAddr = ctl.rdVec ? (VEC_BASE + ADDR_W'(ctl.vecLo)) : spReg;
  assign done    = ctl.finish;
  assign pcOut   = ctl.finish ? {pcReg[ADDR_W-1:HI_LSB], memRdata} : pcReg;
  assign spOut   = spReg;
  assign ccrOut  = ccrReg;
endmodule

// File: rtl/swiEntrySeq.sv
module swiEntrySeq
  import swiSeqPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic [15:0] pcIn,
  input  logic [15:0] spIn,
  input  logic [7:0]  aIn,
  input  logic [7:0]  xIn,
  input  logic [7:0]  ccrIn,
  output logic [15:0] memAddr,
  output logic [7:0]  memWdata,
  output logic        memWe,
  input  logic [7:0]  memRdata,
  output logic        done,
  output logic [15:0] pcOut,
  output logic [15:0] spOut,
  output logic [7:0]  ccrOut
);
  seqCtl_t ctl;

  swiSeqCtrl #(.STEP_W(4)) uCtrl (
    .clk(clk), .rstN(rstN), .start(start), .ctl(ctl)
  );

  swiSeqDatapath #(
    .ADDR_W(16), .DATA_W(8), .VEC_BASE(16'hFFFC), .MASK_BIT(3)
  ) uDp (
    .clk(clk), .rstN(rstN), .ctl(ctl),
    .pcIn(pcIn), .spIn(spIn), .aIn(aIn), .xIn(xIn), .ccrIn(ccrIn),
    .memAddr(memAddr), .memWdata(memWdata), .memWe(memWe), .memRdata(memRdata),
    .done(done), .pcOut(pcOut), .spOut(spOut), .ccrOut(ccrOut)
  );
endmodule

// File: rtl/swiEntrySeqChecker.sv
module swiEntrySeqChecker (
  input logic        clk,
  input logic        rstN,
  input logic        start,
  input logic        done,
  input logic        memWe,
  input logic [15:0] memAddr,
  input logic [15:0] spOut,
  input logic [7:0]  ccrOut
);
  logic [3:0] cnt;

  always_ff @(posedge clk) begin
    if (!rstN)                      cnt <= '0;
    else if (cnt == 4'd0 && start)  cnt <= 4'd1;
    else if (cnt == 4'd9)           cnt <= 4'd0;
    else if (cnt != 4'd0)           cnt <= cnt + 4'd1;
  end

  // R6, R7: completion lands on the ninth cycle of the accepted run only
  a_r6_done_ninth: assert property (@(posedge clk) disable iff (!rstN)
    done == (cnt == 4'd9));

  // R6: single-cycle pulse
  a_r6_done_single: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R9: writes confined to the push window
  a_r9_write_window: assert property (@(posedge clk) disable iff (!rstN)
    memWe |-> (cnt >= 4'd2 && cnt <= 4'd6));

  // R3: stack pointer steps down past each written address
  a_r3_sp_post_dec: assert property (@(posedge clk) disable iff (!rstN)
    memWe |=> (spOut == $past(memAddr) - 16'd1));

  // R4: mask set at completion
  a_r4_mask_set: assert property (@(posedge clk) disable iff (!rstN)
    done |-> ccrOut[3]);

  // R6: idle without a request leaves the stack pointer alone
  a_r6_idle_hold: assert property (@(posedge clk) disable iff (!rstN)
    (cnt == 4'd0 && !start) |=> $stable(spOut));
endmodule

bind swiEntrySeq swiEntrySeqChecker uChk (
  .clk(clk), .rstN(rstN), .start(start), .done(done), .memWe(memWe),
  .memAddr(memAddr), .spOut(spOut), .ccrOut(ccrOut)
);

// File: tb/tb_swiEntrySeq.sv
module tb_swiEntrySeq;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rstN;
  logic        start;
  logic [15:0] pcIn, spIn;
  logic [7:0]  aIn, xIn, ccrIn;
  logic [15:0] memAddr;
  logic [7:0]  memWdata;
  logic        memWe;
  logic [7:0]  memRdata;
  logic        done;
  logic [15:0] pcOut, spOut;
  logic [7:0]  ccrOut;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  logic [7:0]  vecHi, vecLo;
  logic [15:0] wrAddr [5];
  logic [7:0]  wrData [5];
  int          wrCount;

  always #(CLK_PERIOD/2) clk = ~clk;

  swiEntrySeq dut (
    .clk(clk), .rstN(rstN), .start(start),
    .pcIn(pcIn), .spIn(spIn), .aIn(aIn), .xIn(xIn), .ccrIn(ccrIn),
    .memAddr(memAddr), .memWdata(memWdata), .memWe(memWe), .memRdata(memRdata),
    .done(done), .pcOut(pcOut), .spOut(spOut), .ccrOut(ccrOut)
  );

  // memory model: registered read, write log
  always @(posedge clk) begin
    if (memAddr == 16'hFFFC)      memRdata <= vecHi;
    else if (memAddr == 16'hFFFD) memRdata <= vecLo;
    else                          memRdata <= 8'hEE;
    if (memWe) begin
      if (wrCount < 5) begin
        wrAddr[wrCount] = memAddr;
        wrData[wrCount] = memWdata;
      end
      wrCount = wrCount + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic runCase(input logic [15:0] spv, input logic [15:0] pcv,
                         input logic [7:0] av, input logic [7:0] xv, input logic [7:0] ccrv,
                         input logic [7:0] vh, input logic [7:0] vl, input bit inject);
    logic [15:0] pcInc, spEnd, pcEnd;
    logic [7:0]  ccrEnd;
    logic [15:0] expAddr [5];
    logic [7:0]  expData [5];
    pcInc  = pcv + 16'd1;
    spEnd  = spv - 16'd5;
    ccrEnd = ccrv | 8'h08;
    pcEnd  = {vh, vl};
    for (int k = 0; k < 5; k++) expAddr[k] = spv - 16'(k);
    expData[0] = pcInc[7:0];
    expData[1] = pcInc[15:8];
    expData[2] = xv;
    expData[3] = av;
    expData[4] = ccrv;

    @(negedge clk);
    vecHi = vh; vecLo = vl;
    wrCount = 0;
    spIn = spv; pcIn = pcv; aIn = av; xIn = xv; ccrIn = ccrv;
    start = 1'b1;
    @(posedge clk);
    @(negedge clk);                         // step 1
    start = 1'b0;
    chk(!memWe && !done, "R1 no write in first cycle", {30'd0, memWe, done}, 32'd0);
    for (int k = 2; k <= 9; k++) begin
      @(posedge clk);
      @(negedge clk);                       // step k
      start = 1'b0;
      if (inject && k == 4) begin
        start = 1'b1;
        spIn = ~spv; pcIn = ~pcv; aIn = ~av; xIn = ~xv; ccrIn = ~ccrv;
      end
      if (k < 9) chk(!done, "R6 done early", {31'd0, done}, 32'd0);
    end
    if (inject) start = 1'b1;               // request during completion cycle
    chk(done, "R6 done in ninth cycle", {31'd0, done}, 32'd1);
    chk(pcOut == pcEnd, "R5 vector PC", {16'd0, pcOut}, {16'd0, pcEnd});
    chk(spOut == spEnd, "R3 final SP", {16'd0, spOut}, {16'd0, spEnd});
    chk(ccrOut == ccrEnd, "R4 mask set", {24'd0, ccrOut}, {24'd0, ccrEnd});
    chk(wrCount == 5, "R9 write count", wrCount, 32'd5);
    for (int k = 0; k < 5; k++) begin
      chk(wrAddr[k] == expAddr[k], "R3 push address", {16'd0, wrAddr[k]}, {16'd0, expAddr[k]});
      chk(wrData[k] == expData[k], (k < 2) ? "R1 stacked PC" : ((k == 4) ? "R4 stacked CCR" : "R2 push order"),
          {24'd0, wrData[k]}, {24'd0, expData[k]});
    end
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    repeat (12) begin
      @(posedge clk);
      @(negedge clk);
      chk(!done && !memWe, inject ? "R7 no restart" : "R9 idle quiet", {30'd0, done, memWe}, 32'd0);
    end
    chk(pcOut == pcEnd && spOut == spEnd && ccrOut == ccrEnd, "R6 results hold",
        {pcOut, spOut}, {pcEnd, spEnd});
    chk(wrCount == 5, inject ? "R7 no extra writes" : "R9 no extra writes", wrCount, 32'd5);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    wrCount = 0;
    vecHi = 8'h00; vecLo = 8'h00;
    rstN = 1'b0; start = 1'b0;
    pcIn = '0; spIn = '0; aIn = '0; xIn = '0; ccrIn = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(!done && !memWe, "R8 reset controls", {30'd0, done, memWe}, 32'd0);
    chk(pcOut == 0 && spOut == 0 && ccrOut == 0, "R8 reset values", {pcOut, spOut}, 32'd0);
    rstN = 1'b1;
    @(posedge clk);
    @(negedge clk);
    chk(!done && !memWe && pcOut == 0 && spOut == 0, "R8 after reset", {pcOut, spOut}, 32'd0);

    for (int i = 0; i < 16; i++) begin
      logic [15:0] spv, pcv;
      logic [7:0]  av, xv, ccrv, vh, vl;
      spv  = 16'h0002 + 16'(i) * 16'h1357;     // i=0 wraps through 0x0000
      pcv  = (i == 1) ? 16'hFFFF : (16'h00FF + 16'(i) * 16'h0B01);
      av   = 8'h3C ^ 8'(i * 17);
      xv   = 8'hA5 + 8'(i * 29);
      ccrv = 8'(i * 27) & 8'hEF;               // bit 3 set in some runs, clear in others
      vh   = 8'h80 + 8'(i * 7);
      vl   = 8'h11 * 8'(i + 1);
      runCase(spv, pcv, av, xv, ccrv, vh, vl, i[0]);
    end

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule